// File: doc/BRIEF.md
# SIMD Floating-Point Exception Controller

This block sits beside a multi-lane floating-point datapath and turns the exception conditions that the lanes report into a single decision per completed instruction. It owns a 16-bit control/status register holding six sticky exception flags, six per-class mask bits and a denormals-are-zero control. That control is driven straight out to the datapath, which replaces denormal source operands with a zero of the same sign.

When the datapath pulses its completion strobe, the block ORs each exception class across all lanes and sets the matching sticky flags. It then compares the detected classes against the masks. If every detected class is masked, or none was detected, it grants the write of the default result. If any detected class is unmasked, it withholds that write so the operands stay untouched, and it raises one of two traps. The SIMD floating-point trap is chosen when the operating-system support input is high. The invalid-opcode trap is chosen when that input is low. The decision appears as a one-cycle pulse exactly one clock after the strobe, so exceptions are always reported at instruction completion.

Top module: `simd_fp_excp_ctrl`

## Requirements
- R1: After reset the register reads 0x1F80: all six mask bits are set, and all flags and the denormals-are-zero control are clear. All three decision outputs are low.
- R2: A register write stores bits 12..0 of the write data. Bits 15..13 always read as zero.
- R3: Class encoding is used both in each lane's 6-bit condition field and in the flags. Bit 0 is invalid, bit 1 denormal, bit 2 divide-by-zero, bit 3 overflow, bit 4 underflow and bit 5 inexact. The mask for flag bit k sits at bit k+7. On a completion strobe, each flag is set if its class is reported by any lane. A set flag stays set until a register write changes it.
- R4: Lane conditions presented without a completion strobe have no effect on the register or on the decision outputs.
- R5: If a register write and a completion strobe fall in the same cycle, the register takes the written value with that instruction's detected flags ORed on top. The decision uses the masks held before the write.
- R6: If no detected class is unmasked, `commit_en` pulses high for one cycle, one clock after the strobe, and neither trap is raised.
- R7: If a detected class is unmasked and `os_xf_en` is 1, `trap_simd` pulses one clock after the strobe, and `commit_en` stays low.
- R8: If a detected class is unmasked and `os_xf_en` is 0, `trap_undef` pulses one clock after the strobe, and `commit_en` stays low.
- R9: At most one of the three decision outputs is high in any cycle. One of them is high exactly in the cycle after each strobe, and all are low otherwise.
- R10: `daz_en` follows register bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr_en | input | 1 | Register write strobe |
| csr_wr_data | input | 16 | Register write value |
| csr_rd_data | output | 16 | Current register value |
| op_done | input | 1 | Instruction-complete strobe |
| lane_cond | input | LANES*6 | Per-lane exception conditions, lane 0 in the low bits |
| os_xf_en | input | 1 | Operating system handles SIMD floating-point traps |
| commit_en | output | 1 | Default result may be written |
| trap_simd | output | 1 | Raise the SIMD floating-point trap |
| trap_undef | output | 1 | Raise the invalid-opcode trap |
| daz_en | output | 1 | Denormals-are-zero control to the datapath |

## Verification
A software write to the register and an instruction completion can land on the same clock edge. In that case the written value must absorb the newly detected flags, while the trap decision still uses the masks held before the write. The bench provokes this both directly and by issuing random writes alongside random completions. Each time, a model computes the expected register value and decision from the pre-write masks, and compares it with the register read-back and the decision pulse one clock later.

// File: rtl/simd_fpx_pkg.sv
package simd_fpx_pkg;
  localparam int NCLS     = 6;
  localparam int CSR_W    = 16;
  localparam int FLAG_LSB = 0;
  localparam int DAZ_BIT  = 6;
  localparam int MASK_LSB = 7;
  localparam logic [CSR_W-1:0] CSR_RST  = 16'h1F80;
  localparam logic [CSR_W-1:0] WR_KEEP  = 16'h1FFF;

  typedef enum logic [1:0] {
    OUT_IDLE   = 2'd0,
    OUT_COMMIT = 2'd1,
    OUT_XF     = 2'd2,
    OUT_UD     = 2'd3
  } outcome_e;
endpackage

// File: rtl/fpx_rst_sync.sv
module fpx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/fpx_lane_or.sv
module fpx_lane_or #(
  parameter int LANES = 4,
  parameter int NCLS  = 6
) (
  input  logic [LANES*NCLS-1:0] cond,
  output logic [NCLS-1:0]       any_cls
);
  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    logic [LANES-1:0] col;
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign col[l] = cond[l*NCLS + c];
    end
    assign any_cls[c] = |col;
  end
endmodule

// File: rtl/fpx_csr.sv
module fpx_csr
  import simd_fpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  input  logic             set_en,
  input  logic [NCLS-1:0]  set_flags,
  output logic [CSR_W-1:0] csr_q
);
  logic [CSR_W-1:0] csr_nxt;
  logic             csr_ce;

  always_comb begin
    csr_nxt = csr_q;
    if (wr_en) csr_nxt = wr_data & WR_KEEP;
    if (set_en) csr_nxt[FLAG_LSB +: NCLS] = csr_nxt[FLAG_LSB +: NCLS] | set_flags;
  end

  assign csr_ce = wr_en | set_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      csr_q <= CSR_RST;
    else if (csr_ce) csr_q <= csr_nxt;
  end
endmodule

// File: rtl/fpx_decide.sv
module fpx_decide
  import simd_fpx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            done,
  input  logic [NCLS-1:0] detected,
  input  logic [NCLS-1:0] masks,
  input  logic            os_en,
  output logic            commit_en,
  output logic            trap_simd,
  output logic            trap_undef
);
  outcome_e         out_q, out_nxt;
  logic [NCLS-1:0]  unmasked;

  assign unmasked = detected & ~masks;

  always_comb begin
    out_nxt = OUT_IDLE;
    if (done) begin
      if (unmasked == '0) out_nxt = OUT_COMMIT;
      else if (os_en)     out_nxt = OUT_XF;
      else                out_nxt = OUT_UD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= OUT_IDLE;
    else        out_q <= out_nxt;
  end

  assign commit_en  = (out_q == OUT_COMMIT);
  assign trap_simd  = (out_q == OUT_XF);
  assign trap_undef = (out_q == OUT_UD);
endmodule

// File: rtl/simd_fp_excp_ctrl.sv
module simd_fp_excp_ctrl
  import simd_fpx_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  csr_wr_en,
  input  logic [CSR_W-1:0]      csr_wr_data,
  output logic [CSR_W-1:0]      csr_rd_data,
  input  logic                  op_done,
  input  logic [LANES*NCLS-1:0] lane_cond,
  input  logic                  os_xf_en,
  output logic                  commit_en,
  output logic                  trap_simd,
  output logic                  trap_undef,
  output logic                  daz_en
);
  logic             rst_n_int;
  logic [NCLS-1:0]  det_cls;
  logic [CSR_W-1:0] csr_q;

  fpx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  fpx_lane_or #(.LANES(LANES), .NCLS(NCLS)) u_or (
    .cond    (lane_cond),
    .any_cls (det_cls)
  );

  fpx_csr u_csr (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_en     (csr_wr_en),
    .wr_data   (csr_wr_data),
    .set_en    (op_done),
    .set_flags (det_cls),
    .csr_q     (csr_q)
  );

  fpx_decide u_dec (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .done       (op_done),
    .detected   (det_cls),
    .masks      (csr_q[MASK_LSB +: NCLS]),
    .os_en      (os_xf_en),
    .commit_en  (commit_en),
    .trap_simd  (trap_simd),
    .trap_undef (trap_undef)
  );

  assign csr_rd_data = csr_q;
  assign daz_en      = csr_q[DAZ_BIT];
endmodule

// File: rtl/fpx_checker.sv
module fpx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        csr_wr_en,
  input logic [15:0] csr_rd_data,
  input logic        op_done,
  input logic        os_xf_en,
  input logic        commit_en,
  input logic        trap_simd,
  input logic        trap_undef
);
  logic any_out;
  assign any_out = commit_en | trap_simd | trap_undef;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit_en, trap_simd, trap_undef})); // R9
  AST_DONE_GIVES_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> any_out); // R9
  AST_IDLE_NO_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !op_done |=> !any_out); // R9
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_wr_en |=> ((csr_rd_data[5:0] & $past(csr_rd_data[5:0])) == $past(csr_rd_data[5:0]))); // R3
  AST_NO_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_wr_en && !op_done) |=> $stable(csr_rd_data)); // R4
  AST_OS_SET_NO_UD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && os_xf_en) |=> !trap_undef); // R7
  AST_OS_CLR_NO_XF: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !os_xf_en) |=> !trap_simd); // R8
  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd_data[15:13] == 3'b000); // R2
endmodule

bind simd_fp_excp_ctrl fpx_checker u_fpx_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .csr_wr_en   (csr_wr_en),
  .csr_rd_data (csr_rd_data),
  .op_done     (op_done),
  .os_xf_en    (os_xf_en),
  .commit_en   (commit_en),
  .trap_simd   (trap_simd),
  .trap_undef  (trap_undef)
);

// File: tb/test_simd_fp_excp_ctrl.sv
`timescale 1ns/1ps
module test_simd_fp_excp_ctrl;
  localparam int LANES = 4;
  localparam int W = LANES*6;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         csr_wr_en;
  logic [15:0]  csr_wr_data;
  logic [15:0]  csr_rd_data;
  logic         op_done;
  logic [W-1:0] lane_cond;
  logic         os_xf_en;
  logic         commit_en, trap_simd, trap_undef, daz_en;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] model;

  always #4 clk = ~clk;

  simd_fp_excp_ctrl #(.LANES(LANES)) i_simd_fp_excp_ctrl (
    .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data),
    .csr_rd_data(csr_rd_data), .op_done(op_done), .lane_cond(lane_cond),
    .os_xf_en(os_xf_en), .commit_en(commit_en), .trap_simd(trap_simd),
    .trap_undef(trap_undef), .daz_en(daz_en)
  );

  function automatic logic [5:0] or_lanes(input logic [W-1:0] c);
    logic [5:0] r = '0;
    for (int l = 0; l < LANES; l++) r |= c[l*6 +: 6];
    return r;
  endfunction

  function automatic logic [2:0] expect_out(input logic done, input logic [5:0] det,
                                            input logic [15:0] m, input logic os);
    logic [5:0] um;
    um = det & ~m[12:7];
    if (!done) return 3'b000;
    if (um == '0) return 3'b100;
    return os ? 3'b010 : 3'b001;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check at next negedge
  task automatic cycle(input logic wr, input logic [15:0] wd, input logic done,
                       input logic [W-1:0] cond, input logic os, input string req);
    logic [2:0]  eo;
    logic [15:0] nm;
    csr_wr_en = wr; csr_wr_data = wd; op_done = done; lane_cond = cond; os_xf_en = os;
    eo = expect_out(done, or_lanes(cond), model, os);
    nm = wr ? (wd & 16'h1FFF) : model;
    if (done) nm[5:0] = nm[5:0] | or_lanes(cond);
    @(negedge clk);
    model = nm;
    csr_wr_en = 1'b0; op_done = 1'b0; lane_cond = '0;
    chk(req, {29'd0, commit_en, trap_simd, trap_undef}, {29'd0, eo});
    chk(req, {16'd0, csr_rd_data}, {16'd0, model});
    chk("R10", {31'd0, daz_en}, {31'd0, model[6]});
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; csr_wr_en = 0; csr_wr_data = 0; op_done = 0; lane_cond = 0; os_xf_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model = 16'h1F80;
    chk("R1", {16'd0, csr_rd_data}, 32'h1F80);
    chk("R1", {29'd0, commit_en, trap_simd, trap_undef}, 0);
    // R4: conditions without strobe ignored
    cycle(0, 0, 0, {W{1'b1}}, 1, "R4");
    // R6: masked everything -> commit, flags set (lane 3 overflow, lane 1 inexact)
    cycle(0, 0, 1, (W'(6'h08) << 18) | (W'(6'h20) << 6), 1, "R6 R3");
    // R9: idle cycle after outcome
    cycle(0, 0, 0, 0, 0, "R9");
    // R2: write all ones, upper bits drop; unmask all, clear flags, set DAZ
    cycle(1, 16'hFFFF, 0, 0, 0, "R2");
    cycle(1, 16'h0040, 0, 0, 0, "R2 R10");
    // R7: unmasked divide-by-zero, OS on
    cycle(0, 0, 1, W'(6'h04) << 12, 1, "R7");
    // R8: unmasked invalid, OS off
    cycle(0, 0, 1, W'(6'h01), 0, "R8");
    // R3: sticky across op with no conditions (commit)
    cycle(0, 0, 1, 0, 0, "R3 R6");
    // R5: write masks all set and clear flags, same cycle as unmasked underflow
    cycle(1, 16'h1F80, 1, W'(6'h10) << 6, 1, "R5");
    cycle(0, 0, 1, W'(6'h10), 0, "R5 R6");
    // back-to-back strobes
    cycle(1, 16'h0000, 0, 0, 0, "R2");
    cycle(0, 0, 1, W'(6'h02), 0, "R8");
    cycle(0, 0, 1, W'(6'h02), 1, "R7 R9");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] c;
      for (int b = 0; b < W; b++) c[b] = ($urandom % 10) == 0;
      cycle(($urandom % 5) == 0, 16'($urandom), ($urandom % 3) != 0, c,
            1'($urandom), "R3 R5 R6 R7 R8");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule